// File: doc/BRIEF.md
# Five-Channel Timer Tick Prescaler and Source Selector

This block produces the count-enable ticks for five timer channels. Everything runs on one peripheral clock. Two programmable prescalers divide that clock. The first prescaler serves channels 0 and 1, and the second serves channels 2, 3 and 4. Each channel then divides its group's prescaled tick by 2, 4, 8 or 16. Instead of the divided tick, a channel can take pulses from an external clock that belongs to its group. Every output is a single-cycle enable pulse in the peripheral clock domain, ready to advance a timer counter that sits outside this block.

Two configuration words set the block up. The prescale word holds both prescaler values. The select word holds one 4-bit code per channel, and that code sets both the channel's divide ratio and its source. Both words read back exactly as they were written. The written values become active only at the owning group's next prescaler terminal count, so a reprogramming never produces a shortened tick interval.

Each channel holds a source mode. The modes are SRC_DIV2, SRC_DIV4, SRC_DIV8, SRC_DIV16 and SRC_EXT. There is one kind of transition, and it happens only at a group terminal count: the channel latches the mode decoded from its written code. If that mode differs from the current one, the transition also restarts the channel's phase counter. At every other cycle a channel keeps its mode.

Top module: `timer_tick_tree`

## Requirements
- R1: After reset, both configuration words read back as zero and every channel ticks once every 2 clock cycles.
- R2: Prescaler g divides by its value plus one (1 to 256). Prescaler 0 sits in bits 7:0 and prescaler 1 in bits 15:8 of the prescale word (cfg_addr = 0). Prescaler 0 drives channels 0 and 1, and prescaler 1 drives channels 2 to 4.
- R3: The select code of channel i sits in bits 4i+3:4i of the select word (cfg_addr = 1).
- R4: Select codes 0, 1, 2 and 3 give a tick interval of (prescale value + 1) multiplied by 2, 4, 8 and 16 clock cycles respectively.
- R5: Select codes 4 to 15 route the group's external clock to the channel, with one tick per rising edge. External clock 0 serves channels 0 and 1, and external clock 1 serves channels 2 to 4.
- R6: An external tick lasts one cycle. It is high in the cycle that follows the second rising clock edge after the external input rises.
- R7: Written prescale and select values take effect at the group's next prescaler terminal count. The first interval after a change is no shorter than the smaller of the old and new periods, and the next interval equals the new period.
- R8: Readback returns, in the cycle after a write, the prescale fields in bits 15:0 or the select fields in bits 19:0. The higher bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low reset, applied synchronously |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_addr | input | 1 | Word select: 0 selects the prescale word, 1 selects the select word |
| cfg_wdata | input | 20 | Write data |
| cfg_rdata | output | 20 | Readback of the word chosen by cfg_addr |
| ext_clk | input | 2 | Asynchronous external clocks, one per group |
| tick | output | 5 | Per-channel count-enable pulses |

## Verification
The bench uses the default parameters: five channels, a split of two and three channels, and 8-bit prescalers. Random trials with a fixed seed mix all five source modes across both groups, with distinct external clock periods per group, so any swap of a prescaler, a field or an external clock shows up as a wrong interval. A directed case runs the largest ratio, 256 × 16 = 4096 cycles. Further directed cases measure the external-tick latency and reprogram the block mid-period to check that changes are deferred.

// File: rtl/tt_pkg.sv
package tt_pkg;
    localparam int SEL_W = 4;
    localparam int DIV_W = 4;

    typedef enum logic [2:0] {
        SRC_DIV2  = 3'd0,
        SRC_DIV4  = 3'd1,
        SRC_DIV8  = 3'd2,
        SRC_DIV16 = 3'd3,
        SRC_EXT   = 3'd4
    } src_mode_e;

    function automatic src_mode_e decode_sel(input logic [SEL_W-1:0] code);
        if (|code[SEL_W-1:2]) begin
            return SRC_EXT;
        end
        return src_mode_e'({1'b0, code[1:0]});
    endfunction
endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
    parameter int PS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PS_W-1:0] ps_new,
    output logic            ps_tick
);
    logic [PS_W-1:0] cnt_q;
    logic [PS_W-1:0] active_q;

    assign ps_tick = (cnt_q == active_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            active_q <= '0;
        end else if (ps_tick) begin
            cnt_q    <= '0;
            active_q <= ps_new;
        end else begin
            cnt_q    <= cnt_q + 1'b1;
        end
    end

    // R2: the count never runs past the active terminal value
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= active_q);

    // R7: the active ratio changes only at a terminal count
    p_hold_cfg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ps_tick |=> $stable(active_q));
endmodule

// File: rtl/tt_ext_edge.sv
module tt_ext_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic pulse
);
    logic [2:0] sync_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[1:0], async_in};
        end
    end

    assign pulse = sync_q[1] & ~sync_q[2];

    // R6: each detected edge yields exactly one cycle of pulse
    p_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
endmodule

// File: rtl/tt_chan_div.sv
module tt_chan_div
    import tt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ps_tick,
    input  logic             ext_pulse,
    input  logic [SEL_W-1:0] sel_new,
    output logic             tick
);
    src_mode_e        mode_q;
    src_mode_e        mode_next;
    logic [DIV_W-1:0] phase_q;

    assign mode_next = decode_sel(sel_new);

    // state register: mode latches only at the group terminal count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= SRC_DIV2;
        end else if (ps_tick) begin
            mode_q <= mode_next;
        end
    end

    // phase counter restarts when the mode changes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (ps_tick) begin
            if (mode_next != mode_q) begin
                phase_q <= '0;
            end else begin
                phase_q <= phase_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (mode_q)
            SRC_DIV2:  tick = ps_tick & phase_q[0];
            SRC_DIV4:  tick = ps_tick & (&phase_q[1:0]);
            SRC_DIV8:  tick = ps_tick & (&phase_q[2:0]);
            SRC_DIV16: tick = ps_tick & (&phase_q[3:0]);
            SRC_EXT:   tick = ext_pulse;
            default:   tick = 1'b0;
        endcase
    end

    // R4: every tick stems from a prescaled tick or an external pulse
    p_tick_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (ps_tick || ext_pulse));

    // R7: the mode holds between terminal counts
    p_mode_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ps_tick |=> $stable(mode_q));
endmodule

// File: rtl/timer_tick_tree.sv
module timer_tick_tree
    import tt_pkg::*;
#(
    parameter  int NUM_CH  = 5,
    parameter  int GRP0_CH = 2,
    parameter  int PS_W    = 8,
    localparam int SEL_TOT = NUM_CH * SEL_W,
    localparam int PS_TOT  = 2 * PS_W,
    localparam int CFG_W   = (SEL_TOT > PS_TOT) ? SEL_TOT : PS_TOT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic [1:0]        ext_clk,
    output logic [NUM_CH-1:0] tick
);
    logic [PS_TOT-1:0]  ps_word_q;
    logic [SEL_TOT-1:0] sel_word_q;
    logic [1:0]         grp_tick;
    logic [1:0]         ext_pulse;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_word_q  <= '0;
            sel_word_q <= '0;
        end else if (cfg_wr) begin
            if (cfg_addr) begin
                sel_word_q <= cfg_wdata[SEL_TOT-1:0];
            end else begin
                ps_word_q  <= cfg_wdata[PS_TOT-1:0];
            end
        end
    end

    assign cfg_rdata = cfg_addr ? CFG_W'(sel_word_q) : CFG_W'(ps_word_q);

    for (genvar g = 0; g < 2; g++) begin : g_grp
        tt_prescaler #(.PS_W(PS_W)) u_ps (
            .clk     (clk),
            .rst_n   (rst_n),
            .ps_new  (ps_word_q[g*PS_W +: PS_W]),
            .ps_tick (grp_tick[g])
        );

        tt_ext_edge u_ext (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (ext_clk[g]),
            .pulse    (ext_pulse[g])
        );
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam int GRP = (i < GRP0_CH) ? 0 : 1;

        tt_chan_div u_div (
            .clk       (clk),
            .rst_n     (rst_n),
            .ps_tick   (grp_tick[GRP]),
            .ext_pulse (ext_pulse[GRP]),
            .sel_new   (sel_word_q[i*SEL_W +: SEL_W]),
            .tick      (tick[i])
        );
    end

    // R8: the select word reads back as written in the cycle after the write
    p_readback_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr) |=>
            (!cfg_addr || cfg_rdata[SEL_TOT-1:0] == $past(cfg_wdata[SEL_TOT-1:0])));
endmodule

// File: tb/tb_timer_tick_tree.sv
`timescale 1ns/1ps
module tb_timer_tick_tree;
    localparam int NCH = 5;
    localparam int CW  = 20;
    localparam int EXT_PER0 = 14;
    localparam int EXT_PER1 = 22;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic          cfg_addr = 1'b0;
    logic [CW-1:0] cfg_wdata = '0;
    logic [CW-1:0] cfg_rdata;
    logic [1:0]    ext_clk;
    logic [1:0]    ext_gen = 2'b00;
    logic [1:0]    ext_man = 2'b00;
    logic          ext_run = 1'b1;
    logic [NCH-1:0] tick;

    int errs = 0;
    int checks = 0;
    int cyc = 0;
    int last_t [NCH];
    int ival   [NCH];
    int nt     [NCH];
    int ecnt0 = 0;
    int ecnt1 = 0;
    int cur_ps0 = 0;
    int cur_ps1 = 0;
    int cur_code [NCH];

    always #2 clk = ~clk;

    assign ext_clk = ext_run ? ext_gen : ext_man;

    timer_tick_tree dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .ext_clk   (ext_clk),
        .tick      (tick)
    );

    initial begin
        for (int c = 0; c < NCH; c++) begin
            last_t[c] = 0;
            ival[c] = 0;
            nt[c] = 0;
        end
    end

    always @(negedge clk) begin
        cyc = cyc + 1;
        for (int c = 0; c < NCH; c++) begin
            if (tick[c]) begin
                ival[c] = cyc - last_t[c];
                last_t[c] = cyc;
                nt[c] = nt[c] + 1;
            end
        end
        ecnt0 = (ecnt0 + 1) % EXT_PER0;
        ecnt1 = (ecnt1 + 1) % EXT_PER1;
        ext_gen[0] = (ecnt0 < EXT_PER0 / 2);
        ext_gen[1] = (ecnt1 < EXT_PER1 / 2);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_period(input int ch, input int p0, input int p1, input int code);
        int g;
        int ps;
        g = (ch < 2) ? 0 : 1;
        if (code >= 4) return (g == 0) ? EXT_PER0 : EXT_PER1;
        ps = (g == 0) ? p0 : p1;
        return (ps + 1) << (code + 1);
    endfunction

    task automatic cfg_write(input bit addr, input int data);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_addr = addr;
        cfg_wdata = CW'(data);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(input bit addr, output int data);
        @(negedge clk);
        cfg_addr = addr;
        #1;
        data = int'(cfg_rdata);
    endtask

    task automatic set_cfg(input int p0, input int p1);
        int sel;
        sel = 0;
        for (int c = 0; c < NCH; c++) sel = sel | ((cur_code[c] & 15) << (4 * c));
        cur_ps0 = p0;
        cur_ps1 = p1;
        cfg_write(1'b0, (p1 << 8) | p0);
        cfg_write(1'b1, sel);
    endtask

    task automatic wait_ticks(input int ch, input int n, input int cap, input string req);
        int base;
        int w;
        base = nt[ch];
        w = 0;
        while ((nt[ch] - base) < n && w < cap) begin
            @(negedge clk);
            #1;
            w++;
        end
        if ((nt[ch] - base) < n) chk(1'b0, req, nt[ch] - base, n);
    endtask

    task automatic measure_all(input string req, input int cap);
        for (int c = 0; c < NCH; c++) begin
            wait_ticks(c, 3, cap, req);
            chk(ival[c] == exp_period(c, cur_ps0, cur_ps1, cur_code[c]), req,
                ival[c], exp_period(c, cur_ps0, cur_ps1, cur_code[c]));
        end
    endtask

    initial begin
        int rd;
        int r;
        int t0;
        int first;
        r = $urandom(32'd4711);
        for (int c = 0; c < NCH; c++) cur_code[c] = 0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        cfg_read(1'b0, rd);
        chk(rd == 0, "R1 prescale word after reset", rd, 0);
        cfg_read(1'b1, rd);
        chk(rd == 0, "R1 select word after reset", rd, 0);
        measure_all("R1 reset tick interval", 100);

        // R8: readback of random words
        for (int k = 0; k < 3; k++) begin
            int v0;
            int v1;
            v0 = int'($urandom() & 32'hFFFFF);
            v1 = int'($urandom() & 32'hFFFFF);
            cfg_write(1'b0, v0);
            cfg_read(1'b0, rd);
            chk(rd == (v0 & 32'hFFFF), "R8 prescale readback", rd, v0 & 32'hFFFF);
            cfg_write(1'b1, v1);
            cfg_read(1'b1, rd);
            chk(rd == v1, "R8 select readback", rd, v1);
        end

        // R2 R3 R4 R5: random trials across both groups and all modes
        for (int t = 0; t < 8; t++) begin
            int p0;
            int p1;
            p0 = int'($urandom_range(0, 15));
            p1 = int'($urandom_range(0, 15));
            for (int c = 0; c < NCH; c++) begin
                int m;
                m = int'($urandom_range(0, 5));
                cur_code[c] = (m >= 4) ? int'($urandom_range(4, 15)) : m;
            end
            set_cfg(p0, p1);
            repeat (600) @(negedge clk);
            measure_all("R2 R3 R4 R5 random trial interval", 2000);
        end

        // R2 R4: largest ratio in group 1, group 0 independent
        for (int c = 0; c < NCH; c++) cur_code[c] = 0;
        cur_code[2] = 3;
        cur_code[0] = 1;
        set_cfg(3, 255);
        repeat (600) @(negedge clk);
        measure_all("R2 R4 max ratio interval", 15000);

        // R6: external tick latency
        ext_man = 2'b00;
        ext_run = 1'b0;
        for (int c = 0; c < NCH; c++) cur_code[c] = 4;
        set_cfg(0, 0);
        repeat (10) @(negedge clk);
        @(negedge clk);
        ext_man[0] = 1'b1;
        @(posedge clk);
        #1;
        chk(tick[0] == 1'b0, "R6 no tick after first edge", int'(tick[0]), 0);
        @(posedge clk);
        #1;
        chk(tick[0] == 1'b1, "R6 tick after second edge", int'(tick[0]), 1);
        chk(tick[2] == 1'b0, "R5 other group unaffected", int'(tick[2]), 0);
        @(posedge clk);
        #1;
        chk(tick[0] == 1'b0, "R6 tick lasts one cycle", int'(tick[0]), 0);
        repeat (5) @(negedge clk);
        ext_run = 1'b1;

        // R7: deferred select change
        for (int c = 0; c < NCH; c++) cur_code[c] = 0;
        set_cfg(255, 0);
        repeat (600) @(negedge clk);
        wait_ticks(0, 1, 1000, "R7 wait for tick");
        t0 = last_t[0];
        cur_code[0] = 1;
        set_cfg(255, 0);
        wait_ticks(0, 1, 3000, "R7 first tick after select change");
        first = last_t[0] - t0;
        chk(first >= 512, "R7 no short interval after select change", first, 512);
        wait_ticks(0, 1, 3000, "R7 second tick after select change");
        chk(ival[0] == 1024, "R7 new select period", ival[0], 1024);

        // R7: deferred prescale change
        t0 = last_t[0];
        set_cfg(0, 0);
        wait_ticks(0, 1, 3000, "R7 first tick after prescale change");
        first = last_t[0] - t0;
        chk(first >= 4, "R7 no short interval after prescale change", first, 4);
        wait_ticks(0, 1, 100, "R7 second tick after prescale change");
        chk(ival[0] == 4, "R7 new prescale period", ival[0], 4);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        errs++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule